// File: doc/BRIEF.md
# Trap-word evaluation and exception redirect

This block executes the compare-and-trap instruction of a 32-bit core and redirects the processor. The caller delivers one instruction with its address and the values of its two source registers over a valid/ready stream. The block decodes the instruction word and tests the first operand against the second under a five-bit condition mask. It then picks one of four outcomes: an ordinary program interrupt, a halt for an external debugger, a debug interrupt, or a program interrupt that also logs an imprecise debug event. Three debug-mode control pins and the debug-exception enable in the machine state register select the outcome.

The block holds the architectural state that a trap touches: the next program counter, the machine state register, four save/restore registers, the exception-syndrome trap flag and two debug-status flags. All of them update on the clock edge that accepts the instruction. While the block is halted for the debugger, `in_ready` stays low, so the instruction stream is held back. A `resume` pulse releases the halt. An instruction is taken only in a cycle where `in_valid` and `in_ready` are both high. Once the caller raises `in_valid`, the instruction fields must stay stable until that cycle.

Top module: `trap_dispatch`

## Requirements
- R1: In LSB-0 numbering, an instruction is a trap-word only when `insn[31:26]` = 31 and `insn[10:1]` = 4. Any other accepted word behaves as a trap-word whose conditions are all false.
- R2: The condition field is `insn[25:21]`. The trap hits when at least one selected condition holds. The conditions are: `insn[25]` for ra < rb signed, `insn[24]` for ra > rb signed, `insn[23]` for ra = rb, `insn[22]` for ra < rb unsigned, and `insn[21]` for ra > rb unsigned.
- R3: An accepted instruction that does not hit sets pc to the instruction address plus 4. It leaves every other register unchanged.
- R4: A hit with `trap_dbg_en`=0, or with `ext_dbg_mode` and `int_dbg_mode` both 0, takes a program interrupt. srr0 gets the address, srr1 gets the old msr, and `esr_trap` is set. msr bits 18, 15, 14, 5 and 4 are cleared, and pc becomes {vec_prefix, 16'h0700}.
- R5: A hit with `trap_dbg_en`=1 and `ext_dbg_mode`=1 sets `halted` and `dbsr_trap` and sets pc to the instruction address. msr, srr0..srr3 and `esr_trap` stay unchanged.
- R6: In the R5 case, `dbsr_imprecise` is set if and only if `int_dbg_mode`=1 and msr bit 9 is 0.
- R7: A hit with `trap_dbg_en`=1, `ext_dbg_mode`=0, `int_dbg_mode`=1 and msr bit 9 = 1 takes a debug interrupt. srr2 gets the address, srr3 gets the old msr, and `dbsr_trap` is set. msr bits 18, 17, 15, 14, 9, 5 and 4 are cleared, and pc becomes {vec_prefix, 16'h2000}.
- R8: The same case as R7 but with msr bit 9 = 0 sets `dbsr_trap` and `dbsr_imprecise` and also performs every update of R4.
- R9: While `halted` is 1, `in_ready` is 0 and pc does not change. A `resume` pulse clears `halted` at the next edge.
- R10: With `in_valid`=0, no state changes except through `msr_load` or `resume`.
- R11: After reset, pc = RESET_PC (0), msr = RESET_MSR (0), and all other state registers and flags are 0.
- R12: `msr_load` writes `msr_load_val` into msr in a cycle where no instruction is accepted. `esr_trap`, `dbsr_trap` and `dbsr_imprecise` are never cleared except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction |
| insn | input | 32 | Instruction word |
| insn_addr | input | 32 | Address of the instruction |
| ra_val | input | 32 | First operand value |
| rb_val | input | 32 | Second operand value |
| trap_dbg_en | input | 1 | Trap counts as a debug event |
| ext_dbg_mode | input | 1 | External debug mode |
| int_dbg_mode | input | 1 | Internal debug mode |
| vec_prefix | input | 16 | Upper half of the interrupt vector base |
| msr_load | input | 1 | Write msr from msr_load_val |
| msr_load_val | input | 32 | Value for msr_load |
| resume | input | 1 | Release the debugger halt |
| halted | output | 1 | Stopped for the external debugger |
| pc | output | 32 | Next program counter |
| msr | output | 32 | Machine state register |
| srr0 | output | 32 | Program-interrupt return address |
| srr1 | output | 32 | Program-interrupt saved msr |
| srr2 | output | 32 | Debug-interrupt return address |
| srr3 | output | 32 | Debug-interrupt saved msr |
| esr_trap | output | 1 | Syndrome flag: trap-caused program interrupt |
| dbsr_trap | output | 1 | Debug status: trap event |
| dbsr_imprecise | output | 1 | Debug status: imprecise event |

## Verification
The compare logic is swept over every condition mask against operand pairs. The pairs are chosen at the signed and unsigned boundaries (zero, one, all-ones, the most positive and most negative values), so that signed order is told apart from unsigned order and equality from both. Each of the sixteen combinations of the three mode pins and the debug-exception bit is then run from reset with both a hitting and a missing trap. This shows which of the four outcomes is taken and which sticky flags are set. Words with a wrong primary or extended opcode confirm that they never trap. A halt is tested against an instruction held on the stream, and then released with a resume pulse.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int MSR_W = 32;

  localparam int MSR_WE = 18;
  localparam int MSR_CE = 17;
  localparam int MSR_EE = 15;
  localparam int MSR_PR = 14;
  localparam int MSR_DE = 9;
  localparam int MSR_DR = 5;
  localparam int MSR_IR = 4;

  localparam logic [MSR_W-1:0] PROG_CLR =
    (32'd1 << MSR_WE) | (32'd1 << MSR_EE) | (32'd1 << MSR_PR) |
    (32'd1 << MSR_DR) | (32'd1 << MSR_IR);
  localparam logic [MSR_W-1:0] DBG_CLR =
    PROG_CLR | (32'd1 << MSR_CE) | (32'd1 << MSR_DE);

  localparam logic [5:0] PRIM_OP = 6'd31;
  localparam logic [9:0] EXT_OP  = 10'd4;
  localparam int COND_N = 5;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_PROG,
    TK_STOP,
    TK_DBGINT,
    TK_IMPREC
  } trap_kind_e;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
(
  input  logic [31:0]       insn,
  output logic              is_tw,
  output logic [COND_N-1:0] cond_mask
);
  logic prim_ok;
  logic ext_ok;

  assign prim_ok   = (insn[31:26] == PRIM_OP);
  assign ext_ok    = (insn[10:1] == EXT_OP);
  assign is_tw     = prim_ok & ext_ok;
  assign cond_mask = insn[25:21];
endmodule

// File: rtl/trap_cond.sv
module trap_cond
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              enable,
  input  logic [COND_N-1:0] cond_mask,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  output logic              hit
);
  logic [COND_N-1:0] sel;

  // Condition index i is taken from mask bit COND_N-1-i (field MSB first).
  for (genvar i = 0; i < COND_N; i++) begin : g_cond
    logic rel;
    if (i == 0) begin : g_slt
      assign rel = $signed(op_a) < $signed(op_b);
    end else if (i == 1) begin : g_sgt
      assign rel = $signed(op_a) > $signed(op_b);
    end else if (i == 2) begin : g_eq
      assign rel = (op_a == op_b);
    end else if (i == 3) begin : g_ult
      assign rel = op_a < op_b;
    end else begin : g_ugt
      assign rel = op_a > op_b;
    end
    assign sel[i] = cond_mask[COND_N-1-i] & rel;
  end

  assign hit = enable & (|sel);
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
(
  input  logic       hit,
  input  logic       trap_dbg_en,
  input  logic       ext_dbg_mode,
  input  logic       int_dbg_mode,
  input  logic       dbg_exc_en,
  output trap_kind_e kind,
  output logic       log_imprecise
);
  always_comb begin
    kind          = TK_NONE;
    log_imprecise = 1'b0;
    if (hit) begin
      if (!trap_dbg_en || (!ext_dbg_mode && !int_dbg_mode)) begin
        kind = TK_PROG;
      end else if (ext_dbg_mode) begin
        kind          = TK_STOP;
        log_imprecise = int_dbg_mode & ~dbg_exc_en;
      end else if (dbg_exc_en) begin
        kind = TK_DBGINT;
      end else begin
        kind          = TK_IMPREC;
        log_imprecise = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter int               PFX_W     = 16,
  parameter logic [XLEN-1:0]  RESET_PC  = '0,
  parameter logic [MSR_W-1:0] RESET_MSR = '0,
  parameter logic [15:0]      PROG_OFS  = 16'h0700,
  parameter logic [15:0]      DBG_OFS   = 16'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       insn,
  input  logic [XLEN-1:0]   insn_addr,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  input  logic              trap_dbg_en,
  input  logic              ext_dbg_mode,
  input  logic              int_dbg_mode,
  input  logic [PFX_W-1:0]  vec_prefix,
  input  logic              msr_load,
  input  logic [MSR_W-1:0]  msr_load_val,
  input  logic              resume,
  output logic              halted,
  output logic [XLEN-1:0]   pc,
  output logic [MSR_W-1:0]  msr,
  output logic [XLEN-1:0]   srr0,
  output logic [MSR_W-1:0]  srr1,
  output logic [XLEN-1:0]   srr2,
  output logic [MSR_W-1:0]  srr3,
  output logic              esr_trap,
  output logic              dbsr_trap,
  output logic              dbsr_imprecise
);
  localparam int OFS_W = XLEN - PFX_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic              accept;
  logic              is_tw;
  logic [COND_N-1:0] cond_mask;
  logic              hit;
  trap_kind_e        kind;
  logic              log_imprecise;
  logic [XLEN-1:0]   prog_vec;
  logic [XLEN-1:0]   dbg_vec;

  assign in_ready = ~halted;
  assign accept   = in_valid & in_ready;
  assign prog_vec = {vec_prefix, OFS_W'(PROG_OFS)};
  assign dbg_vec  = {vec_prefix, OFS_W'(DBG_OFS)};

  trap_decode u_decode (
    .insn      (insn),
    .is_tw     (is_tw),
    .cond_mask (cond_mask)
  );

  trap_cond #(.XLEN(XLEN)) u_cond (
    .enable    (is_tw),
    .cond_mask (cond_mask),
    .op_a      (ra_val),
    .op_b      (rb_val),
    .hit       (hit)
  );

  trap_route u_route (
    .hit           (hit),
    .trap_dbg_en   (trap_dbg_en),
    .ext_dbg_mode  (ext_dbg_mode),
    .int_dbg_mode  (int_dbg_mode),
    .dbg_exc_en    (msr[MSR_DE]),
    .kind          (kind),
    .log_imprecise (log_imprecise)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted         <= 1'b0;
      pc             <= RESET_PC;
      msr            <= RESET_MSR;
      srr0           <= '0;
      srr1           <= '0;
      srr2           <= '0;
      srr3           <= '0;
      esr_trap       <= 1'b0;
      dbsr_trap      <= 1'b0;
      dbsr_imprecise <= 1'b0;
    end else begin
      if (halted && resume) halted <= 1'b0;
      if (accept) begin
        if (log_imprecise) dbsr_imprecise <= 1'b1;
        unique case (kind)
          TK_NONE: pc <= insn_addr + STEP;
          TK_PROG, TK_IMPREC: begin
            srr0     <= insn_addr;
            srr1     <= msr;
            esr_trap <= 1'b1;
            msr      <= msr & ~PROG_CLR;
            pc       <= prog_vec;
            if (kind == TK_IMPREC) dbsr_trap <= 1'b1;
          end
          TK_STOP: begin
            halted    <= 1'b1;
            dbsr_trap <= 1'b1;
            pc        <= insn_addr;
          end
          TK_DBGINT: begin
            srr2      <= insn_addr;
            srr3      <= msr;
            dbsr_trap <= 1'b1;
            msr       <= msr & ~DBG_CLR;
            pc        <= dbg_vec;
          end
          default: pc <= pc;
        endcase
      end else if (msr_load) begin
        msr <= msr_load_val;
      end
    end
  end

  // R3: a miss only advances pc
  a_r3_quiet_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == TK_NONE) |=>
      ($stable(msr) && $stable(srr0) && $stable(srr2) &&
       pc == $past(insn_addr) + STEP));

  // R4: program interrupt lands on its vector with the syndrome flag set
  a_r4_prog_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == TK_PROG) |=>
      (pc[OFS_W-1:0] == OFS_W'(PROG_OFS) && esr_trap && !msr[MSR_EE]));

  // R5: debug stop freezes on the trap address
  a_r5_stop_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == TK_STOP) |=>
      (halted && pc == $past(insn_addr) && $stable(msr)));

  // R7: debug interrupt disables further debug exceptions
  a_r7_dbgint_de: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == TK_DBGINT) |=>
      (!msr[MSR_DE] && dbsr_trap && pc[OFS_W-1:0] == OFS_W'(DBG_OFS)));

  // R9: pc frozen while halted
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc));

  // R12: sticky status flags
  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_trap || dbsr_trap || dbsr_imprecise) |=>
      ((!$past(esr_trap) || esr_trap) && (!$past(dbsr_trap) || dbsr_trap) &&
       (!$past(dbsr_imprecise) || dbsr_imprecise)));
endmodule

// File: tb/trap_dispatch_test.sv
module trap_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] insn, insn_addr, ra_val, rb_val;
  logic        trap_dbg_en, ext_dbg_mode, int_dbg_mode;
  logic [15:0] vec_prefix;
  logic        msr_load;
  logic [31:0] msr_load_val;
  logic        resume;
  logic        halted;
  logic [31:0] pc, msr, srr0, srr1, srr2, srr3;
  logic        esr_trap, dbsr_trap, dbsr_imprecise;

  int checks = 0;
  int fails  = 0;

  // expected state
  logic [31:0] e_pc, e_msr, e_s0, e_s1, e_s2, e_s3;
  logic        e_esr, e_dt, e_di, e_halt;

  localparam logic [31:0] M_PROG = (32'd1<<18)|(32'd1<<15)|(32'd1<<14)|(32'd1<<5)|(32'd1<<4);
  localparam logic [31:0] M_DBG  = M_PROG | (32'd1<<17) | (32'd1<<9);

  always #2 clk = ~clk;

  trap_dispatch uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .insn_addr(insn_addr), .ra_val(ra_val), .rb_val(rb_val),
    .trap_dbg_en(trap_dbg_en), .ext_dbg_mode(ext_dbg_mode), .int_dbg_mode(int_dbg_mode),
    .vec_prefix(vec_prefix), .msr_load(msr_load), .msr_load_val(msr_load_val),
    .resume(resume), .halted(halted), .pc(pc), .msr(msr), .srr0(srr0), .srr1(srr1),
    .srr2(srr2), .srr3(srr3), .esr_trap(esr_trap), .dbsr_trap(dbsr_trap),
    .dbsr_imprecise(dbsr_imprecise)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "pc", pc, e_pc);
    chk(tag, "msr", msr, e_msr);
    chk(tag, "srr0", srr0, e_s0);
    chk(tag, "srr1", srr1, e_s1);
    chk(tag, "srr2", srr2, e_s2);
    chk(tag, "srr3", srr3, e_s3);
    chk(tag, "esr_trap", 32'(esr_trap), 32'(e_esr));
    chk(tag, "dbsr_trap", 32'(dbsr_trap), 32'(e_dt));
    chk(tag, "dbsr_imprecise", 32'(dbsr_imprecise), 32'(e_di));
    chk(tag, "halted", 32'(halted), 32'(e_halt));
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] to, input logic [9:0] xo);
    return {op, to, 5'd3, 5'd4, xo, 1'b0};
  endfunction

  // R2 conditions evaluated arithmetically
  function automatic logic cond_true(input logic [4:0] to, input logic [31:0] a, input logic [31:0] b);
    logic r;
    r = 1'b0;
    if (to[4] && $signed(a) < $signed(b)) r = 1'b1;
    if (to[3] && $signed(a) > $signed(b)) r = 1'b1;
    if (to[2] && a == b) r = 1'b1;
    if (to[1] && a < b) r = 1'b1;
    if (to[0] && a > b) r = 1'b1;
    return r;
  endfunction

  task automatic model_reset();
    e_pc = 0; e_msr = 0; e_s0 = 0; e_s1 = 0; e_s2 = 0; e_s3 = 0;
    e_esr = 0; e_dt = 0; e_di = 0; e_halt = 0;
  endtask

  task automatic model_prog(input logic [31:0] a);
    e_s0 = a; e_s1 = e_msr; e_esr = 1; e_msr = e_msr & ~M_PROG; e_pc = {vec_prefix, 16'h0700};
  endtask

  task automatic model_issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] x, input logic [31:0] y);
    logic tw, h, de;
    tw = (w[31:26] == 6'd31) && (w[10:1] == 10'd4);
    h  = tw && cond_true(w[25:21], x, y);
    de = e_msr[9];
    if (!h) e_pc = a + 4;
    else if (!trap_dbg_en || (!ext_dbg_mode && !int_dbg_mode)) model_prog(a);
    else if (ext_dbg_mode) begin
      e_halt = 1; e_dt = 1; e_pc = a;
      if (int_dbg_mode && !de) e_di = 1;
    end else if (de) begin
      e_s2 = a; e_s3 = e_msr; e_dt = 1; e_msr = e_msr & ~M_DBG; e_pc = {vec_prefix, 16'h2000};
    end else begin
      e_dt = 1; e_di = 1; model_prog(a);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] x, input logic [31:0] y);
    insn = w; insn_addr = a; ra_val = x; rb_val = y; in_valid = 1;
    @(posedge clk);
    model_issue(w, a, x, y);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic load_msr(input logic [31:0] v);
    msr_load = 1; msr_load_val = v;
    @(posedge clk);
    e_msr = v;
    @(negedge clk);
    msr_load = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    in_valid = 0; insn = 0; insn_addr = 0; ra_val = 0; rb_val = 0;
    trap_dbg_en = 0; ext_dbg_mode = 0; int_dbg_mode = 0; vec_prefix = 16'hA5C0;
    msr_load = 0; msr_load_val = 0; resume = 0; rst_n = 0;
    @(negedge clk);
    do_reset();
    chk_all("R11");
    chk("R11", "in_ready", 32'(in_ready), 32'd1);

    // R2/R3/R4: condition sweep, trap as program interrupt
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int t = 0; t < 32; t++) begin
          load_msr(32'h9E37_79B9 * 32'(i*192 + j*32 + t + 1));
          issue(enc(6'd31, 5'(t), 10'd4), 32'h1000 + 32'(t*4), vals[i], vals[j]);
          chk_all(cond_true(5'(t), vals[i], vals[j]) ? "R4" : "R2");
        end

    // R1: wrong opcodes never trap
    issue(enc(6'd30, 5'h1F, 10'd4), 32'h2000, 32'd1, 32'd2);
    chk_all("R1");
    issue(enc(6'd31, 5'h1F, 10'd5), 32'h2004, 32'd1, 32'd2);
    chk_all("R1");

    // R10: stimulus without valid
    insn = enc(6'd31, 5'h1F, 10'd4); insn_addr = 32'h3000; ra_val = 1; rb_val = 2;
    @(posedge clk); @(negedge clk);
    chk_all("R10");

    // R5..R9: every mode combination from reset, hit and miss
    for (int m = 0; m < 16; m++) begin
      do_reset();
      trap_dbg_en = m[3]; ext_dbg_mode = m[2]; int_dbg_mode = m[1];
      load_msr(m[0] ? 32'hFFFF_FFFF : 32'hFFFF_FDFF);
      chk("R12", "msr_load", msr, e_msr);
      issue(enc(6'd31, 5'b00100, 10'd4), 32'h4000, 32'd7, 32'd8);
      chk_all("R3");
      issue(enc(6'd31, 5'b00100, 10'd4), 32'h4100 + 32'(m*16), 32'd9, 32'd9);
      chk_all(m[3] && m[2] ? "R6" : (m[3] && m[1] ? (m[0] ? "R7" : "R8") : "R4"));
      if (e_halt) begin
        chk("R9", "in_ready", 32'(in_ready), 32'd0);
        insn = enc(6'd31, 5'b00100, 10'd4); insn_addr = 32'h5000; in_valid = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        chk_all("R9");
        resume = 1;
        @(posedge clk);
        e_halt = 0;
        @(negedge clk);
        resume = 0;
        chk_all("R9");
        chk("R9", "in_ready", 32'(in_ready), 32'd1);
        issue(enc(6'd31, 5'b00000, 10'd4), 32'h6000, 32'd0, 32'd0);
        chk_all("R5");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule